// File: doc/BRIEF.md
# Controller Command and Event Status Port

This block is the single 16-bit host port through which driver software steers a network controller. A host write carries a command word: a five-bit opcode and an eleven-bit argument. The block decodes it into register updates: active register window, transmit and receive enables, download and upload stall flags, the interrupt mask and the indication mask, and event acknowledgement. Commands that need work in another part of the controller start a request/done handshake: a full reset, a transmit-path reset or a receive-path reset.

The read side of the same port is a status word. It holds the latched event bits, an interrupt summary bit, a command-busy flag and the active window. Software writes a command, then polls the busy flag until it drops before it writes the next command. Events are latched only when their indication bit is enabled. Each latched event stays set until software acknowledges it with a mask. The interrupt line is high whenever a latched event is also enabled in the interrupt mask.

Top module: `cmdport_top`

## Requirements
- R1: A command word carries the opcode in bits 15:11 and the argument in bits 10:0. The opcodes are: 0 full reset, 1 window select, 2 transmit reset, 3 receive reset, 4 transmit on, 5 transmit off, 6 receive on, 7 receive off, 8 stall control, 9 acknowledge, 10 load interrupt mask, 11 load indication mask.
- R2: A write of opcodes 1 and 4 to 11 takes effect at the clock edge that samples it. Busy (status bit 12) is then high for exactly one cycle.
- R3: Opcodes 0, 2 and 3 raise `act_req` with `act_code` 0, 1 or 2 respectively, and keep busy high. Both hold until `act_done` is sampled high while the request is up. In the cycle after that, both are low. `act_done` has no effect while no request is up.
- R4: A write presented while busy is high is discarded and changes no state.
- R5: Window select stores argument bits WIN_W-1:0 as the active window. The window is driven on `window` and on status bits 15:13.
- R6: Opcodes 10 and 11 load argument bits EVT_W-1:0 into the interrupt mask and the indication mask respectively. Both masks reset to zero.
- R7: An `evt_in` pulse on bit i sets status bit i only if indication-mask bit i is set at that edge. A set status bit stays set until it is acknowledged or a full reset completes.
- R8: Acknowledge clears exactly the status event bits whose argument bits are 1. An event pulse arriving at the same edge as an acknowledge of that bit leaves the bit set.
- R9: `irq` and status bit 11 are high exactly when some latched event bit is also set in the interrupt mask.
- R10: Stall control decodes argument bits 1:0 as follows: 0 sets `dn_stall`, 1 clears `dn_stall`, 2 sets `up_stall`, 3 clears `up_stall`.
- R11: Opcodes 4 and 5 set and clear `tx_en`. Opcodes 6 and 7 set and clear `rx_en`.
- R12: After `rst_n`, and at the edge where a full reset's done is sampled, the following all return to zero: window, masks, enables, stalls and events. `stn_mask_clr` is high for exactly the one following cycle after a full reset completes.
- R13: Opcodes 12 to 31 change no state and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host command write strobe |
| wr_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| rd_data | output | 16 | Status: window 15:13, busy 12, irq 11, events 10:0 |
| irq | output | 1 | Interrupt request |
| evt_in | input | EVT_W | Event pulses from the controller datapaths |
| act_req | output | 1 | Downstream action request |
| act_code | output | 2 | Action selector: 0 full, 1 transmit, 2 receive |
| act_done | input | 1 | Downstream action finished |
| window | output | WIN_W | Active register window |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| dn_stall | output | 1 | Download engine stall |
| up_stall | output | 1 | Upload engine stall |
| stn_mask_clr | output | 1 | One-cycle clear of the station mask |

## Verification
The bench uses the defaults EVT_W = 11 and WIN_W = 3. With these values every argument bit maps onto an event bit and the status word has no padding. Every acknowledge and mask pattern therefore lands on a real event bit, and the window field covers all of bits 15:13. Sparse random event pulses, random argument masks and random done latency bring three situations within reach. They are same-edge set/acknowledge collisions, masked-off events, and writes that arrive during a long handshake.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  localparam int CMD_W = 16;
  localparam int OPC_W = 5;
  localparam int ARG_W = CMD_W - OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_RESET_ALL = 5'd0,
    OPC_WINDOW    = 5'd1,
    OPC_TX_RESET  = 5'd2,
    OPC_RX_RESET  = 5'd3,
    OPC_TX_ON     = 5'd4,
    OPC_TX_OFF    = 5'd5,
    OPC_RX_ON     = 5'd6,
    OPC_RX_OFF    = 5'd7,
    OPC_STALL     = 5'd8,
    OPC_ACK       = 5'd9,
    OPC_INT_MASK  = 5'd10,
    OPC_IND_MASK  = 5'd11
  } opc_e;

  typedef enum logic [1:0] {
    ACT_GLOBAL = 2'd0,
    ACT_TX     = 2'd1,
    ACT_RX     = 2'd2,
    ACT_NONE   = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    STL_DN_ON  = 2'd0,
    STL_DN_OFF = 2'd1,
    STL_UP_ON  = 2'd2,
    STL_UP_OFF = 2'd3
  } stall_e;

  typedef struct packed {
    logic valid;
    logic downstream;
    act_e act;
    logic win;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
    logic stall;
    logic ack;
    logic int_ld;
    logic ind_ld;
  } cmd_dec_t;

  function automatic logic [OPC_W-1:0] opc_of(input logic [CMD_W-1:0] w);
    return w[CMD_W-1:ARG_W];
  endfunction

  function automatic logic [ARG_W-1:0] arg_of(input logic [CMD_W-1:0] w);
    return w[ARG_W-1:0];
  endfunction

  // One event bit: a qualified set wins over an acknowledge, a completed
  // full reset wins over both.
  function automatic logic evt_bit_next(input logic cur, input logic set,
                                        input logic ack, input logic clr);
    logic n;
    n = cur;
    if (ack) n = 1'b0;
    if (set) n = 1'b1;
    if (clr) n = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
  import cmdport_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_dec_t         dec,
  output logic [ARG_W-1:0] arg
);
  logic [OPC_W-1:0] opc;

  assign opc = opc_of(word);
  assign arg = arg_of(word);

  always_comb begin
    dec     = '0;
    dec.act = ACT_NONE;
    case (opc)
      OPC_RESET_ALL: begin dec.valid = 1'b1; dec.downstream = 1'b1; dec.act = ACT_GLOBAL; end
      OPC_TX_RESET:  begin dec.valid = 1'b1; dec.downstream = 1'b1; dec.act = ACT_TX;     end
      OPC_RX_RESET:  begin dec.valid = 1'b1; dec.downstream = 1'b1; dec.act = ACT_RX;     end
      OPC_WINDOW:    begin dec.valid = 1'b1; dec.win    = 1'b1; end
      OPC_TX_ON:     begin dec.valid = 1'b1; dec.tx_on  = 1'b1; end
      OPC_TX_OFF:    begin dec.valid = 1'b1; dec.tx_off = 1'b1; end
      OPC_RX_ON:     begin dec.valid = 1'b1; dec.rx_on  = 1'b1; end
      OPC_RX_OFF:    begin dec.valid = 1'b1; dec.rx_off = 1'b1; end
      OPC_STALL:     begin dec.valid = 1'b1; dec.stall  = 1'b1; end
      OPC_ACK:       begin dec.valid = 1'b1; dec.ack    = 1'b1; end
      OPC_INT_MASK:  begin dec.valid = 1'b1; dec.int_ld = 1'b1; end
      OPC_IND_MASK:  begin dec.valid = 1'b1; dec.ind_ld = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmdport_seq.sv
module cmdport_seq
  import cmdport_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  cmd_dec_t dec,
  input  logic     act_done,
  output logic     busy,
  output logic     act_req,
  output act_e     act_code,
  output logic     glob_done,
  output logic     stn_mask_clr
);
  logic pend_q;
  act_e code_q;

  assign act_req   = pend_q;
  assign act_code  = code_q;
  assign glob_done = pend_q && act_done && (code_q == ACT_GLOBAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      pend_q       <= 1'b0;
      code_q       <= ACT_NONE;
      stn_mask_clr <= 1'b0;
    end else begin
      stn_mask_clr <= glob_done;
      if (fire) begin
        busy   <= 1'b1;
        pend_q <= dec.downstream;
        code_q <= dec.downstream ? dec.act : ACT_NONE;
      end else if (pend_q) begin
        if (act_done) begin
          busy   <= 1'b0;
          pend_q <= 1'b0;
          code_q <= ACT_NONE;
        end
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs
  import cmdport_pkg::*;
#(
  parameter int EVT_W = 11,
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             clr_all,
  input  cmd_dec_t         dec,
  input  logic [ARG_W-1:0] arg,
  output logic [WIN_W-1:0] window,
  output logic [EVT_W-1:0] int_mask,
  output logic [EVT_W-1:0] ind_mask,
  output logic             tx_en,
  output logic             rx_en,
  output logic             dn_stall,
  output logic             up_stall
);
  stall_e stl;
  assign stl = stall_e'(arg[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window   <= '0;
      int_mask <= '0;
      ind_mask <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      dn_stall <= 1'b0;
      up_stall <= 1'b0;
    end else if (clr_all) begin
      window   <= '0;
      int_mask <= '0;
      ind_mask <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      dn_stall <= 1'b0;
      up_stall <= 1'b0;
    end else if (fire) begin
      if (dec.win)    window   <= arg[WIN_W-1:0];
      if (dec.int_ld) int_mask <= arg[EVT_W-1:0];
      if (dec.ind_ld) ind_mask <= arg[EVT_W-1:0];
      if (dec.tx_on)  tx_en    <= 1'b1;
      if (dec.tx_off) tx_en    <= 1'b0;
      if (dec.rx_on)  rx_en    <= 1'b1;
      if (dec.rx_off) rx_en    <= 1'b0;
      if (dec.stall) begin
        case (stl)
          STL_DN_ON:  dn_stall <= 1'b1;
          STL_DN_OFF: dn_stall <= 1'b0;
          STL_UP_ON:  up_stall <= 1'b1;
          STL_UP_OFF: up_stall <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdport_events.sv
module cmdport_events
  import cmdport_pkg::*;
#(
  parameter int EVT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             ack_fire,
  input  logic [EVT_W-1:0] ack_mask,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [EVT_W-1:0] ind_mask,
  input  logic [EVT_W-1:0] int_mask,
  output logic [EVT_W-1:0] evt_q,
  output logic             irq
);
  for (genvar g = 0; g < EVT_W; g++) begin : g_bit
    logic set_b, ack_b;
    assign set_b = evt_in[g] & ind_mask[g];
    assign ack_b = ack_fire & ack_mask[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else        evt_q[g] <= evt_bit_next(evt_q[g], set_b, ack_b, clr_all);
    end
  end

  assign irq = |(evt_q & int_mask);
endmodule

// File: rtl/cmdport_top.sv
module cmdport_top
  import cmdport_pkg::*;
#(
  parameter int EVT_W = 11,
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  output logic             irq,
  input  logic [EVT_W-1:0] evt_in,
  output logic             act_req,
  output logic [1:0]       act_code,
  input  logic             act_done,
  output logic [WIN_W-1:0] window,
  output logic             tx_en,
  output logic             rx_en,
  output logic             dn_stall,
  output logic             up_stall,
  output logic             stn_mask_clr
);
  localparam int EVT_LSB  = 0;
  localparam int IRQ_BIT  = ARG_W - (ARG_W - 11);
  localparam int BUSY_BIT = IRQ_BIT + 1;
  localparam int WIN_LSB  = BUSY_BIT + 1;

  cmd_dec_t         dec;
  logic [ARG_W-1:0] arg;
  logic             busy;
  logic             accept;
  logic             fire;
  logic             fire_simple;
  logic             fire_ack;
  logic             fire_win;
  logic             glob_done;
  act_e             code;
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] int_mask;
  logic [EVT_W-1:0] ind_mask;

  // named events used by the bound checker
  assign accept      = wr_en && !busy;
  assign fire        = accept && dec.valid;
  assign fire_simple = fire && !dec.downstream;
  assign fire_ack    = fire && dec.ack;
  assign fire_win    = fire && dec.win;

  cmdport_decode u_dec (
    .word (wr_data),
    .dec  (dec),
    .arg  (arg)
  );

  cmdport_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .dec          (dec),
    .act_done     (act_done),
    .busy         (busy),
    .act_req      (act_req),
    .act_code     (code),
    .glob_done    (glob_done),
    .stn_mask_clr (stn_mask_clr)
  );
  assign act_code = code;

  cmdport_regs #(.EVT_W(EVT_W), .WIN_W(WIN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .clr_all  (glob_done),
    .dec      (dec),
    .arg      (arg),
    .window   (window),
    .int_mask (int_mask),
    .ind_mask (ind_mask),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .dn_stall (dn_stall),
    .up_stall (up_stall)
  );

  cmdport_events #(.EVT_W(EVT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (glob_done),
    .ack_fire (fire_ack),
    .ack_mask (arg[EVT_W-1:0]),
    .evt_in   (evt_in),
    .ind_mask (ind_mask),
    .int_mask (int_mask),
    .evt_q    (evt_q),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    rd_data[EVT_LSB +: EVT_W] = evt_q;
    rd_data[IRQ_BIT]          = irq;
    rd_data[BUSY_BIT]         = busy;
    rd_data[WIN_LSB +: WIN_W] = window;
  end
endmodule

// File: rtl/cmdport_chk.sv
module cmdport_chk #(
  parameter int EVT_W = 11,
  parameter int WIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             fire_simple,
  input logic             fire_ack,
  input logic             fire_win,
  input logic             act_req,
  input logic [1:0]       act_code,
  input logic             act_done,
  input logic [15:0]      wr_data,
  input logic [15:0]      rd_data,
  input logic [EVT_W-1:0] evt_in,
  input logic [EVT_W-1:0] evt_q,
  input logic             irq,
  input logic [WIN_W-1:0] window,
  input logic             tx_en,
  input logic             rx_en,
  input logic             stn_mask_clr
);
  // R2: register commands hold busy for one cycle only
  p_simple_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_simple |=> busy && !act_req ##1 !busy);

  // R3: request and selector hold until done
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_req && !act_done |=> act_req && busy && $stable(act_code));

  // R3: request and busy drop after done
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_req && act_done |=> !act_req && !busy);

  // R4: no state change while a command is outstanding
  p_busy_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !act_done |=> $stable(window) && $stable(tx_en) && $stable(rx_en));

  // R5: window takes the argument
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_win |=> window == $past(wr_data[WIN_W-1:0]));

  // R8: acknowledge with no new events leaves the masked bits clear
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ack && (evt_in == '0) |=> (evt_q & $past(wr_data[EVT_W-1:0])) == '0);

  // R9: no latched event means no interrupt
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == '0) |-> !irq);

  // R9: status summary bit mirrors the line
  p_irq_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[11] == irq);

  // R12: station mask clear is a single pulse
  p_clr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stn_mask_clr |=> !stn_mask_clr);
endmodule

bind cmdport_top cmdport_chk #(.EVT_W(EVT_W), .WIN_W(WIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .fire_simple  (fire_simple),
  .fire_ack     (fire_ack),
  .fire_win     (fire_win),
  .act_req      (act_req),
  .act_code     (act_code),
  .act_done     (act_done),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .evt_in       (evt_in),
  .evt_q        (evt_q),
  .irq          (irq),
  .window       (window),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .stn_mask_clr (stn_mask_clr)
);

// File: tb/cmdport_top_tb_top.sv
module cmdport_top_tb_top;
  localparam int EVT_W = 11;
  localparam int WIN_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [15:0]      wr_data = '0;
  logic [15:0]      rd_data;
  logic             irq;
  logic [EVT_W-1:0] evt_in = '0;
  logic             act_req;
  logic [1:0]       act_code;
  logic             act_done = 1'b0;
  logic [WIN_W-1:0] window;
  logic             tx_en, rx_en, dn_stall, up_stall, stn_mask_clr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [WIN_W-1:0] m_win;
  logic [EVT_W-1:0] m_evt, m_int, m_ind;
  logic m_tx, m_rx, m_dn, m_up, m_busy, m_pend, m_clr;
  logic [1:0] m_code;

  always #10 clk = ~clk;

  cmdport_top #(.EVT_W(EVT_W), .WIN_W(WIN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .evt_in(evt_in), .act_req(act_req),
    .act_code(act_code), .act_done(act_done), .window(window),
    .tx_en(tx_en), .rx_en(rx_en), .dn_stall(dn_stall), .up_stall(up_stall),
    .stn_mask_clr(stn_mask_clr)
  );

  function automatic logic exp_irq(input logic [EVT_W-1:0] e, input logic [EVT_W-1:0] m);
    for (int i = 0; i < EVT_W; i++) if (e[i] && m[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [EVT_W-1:0] exp_evt(input logic [EVT_W-1:0] cur,
      input logic [EVT_W-1:0] pulses, input logic [EVT_W-1:0] ind,
      input logic [EVT_W-1:0] ackm);
    return (cur & ~ackm) | (pulses & ind);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_win = '0; m_evt = '0; m_int = '0; m_ind = '0;
    m_tx = 0; m_rx = 0; m_dn = 0; m_up = 0;
    m_busy = 0; m_pend = 0; m_clr = 0; m_code = 2'd0;
  endtask

  task automatic compare_all();
    logic ei;
    ei = exp_irq(m_evt, m_int);
    check("R5 window port", window, m_win);
    check("R5 status window", rd_data[15:13], m_win);
    check("R2 R3 status busy", rd_data[12], m_busy);
    check("R7 R8 status events", rd_data[10:0], m_evt);
    check("R9 irq", irq, ei);
    check("R9 status irq bit", rd_data[11], ei);
    check("R11 tx_en", tx_en, m_tx);
    check("R11 rx_en", rx_en, m_rx);
    check("R10 dn_stall", dn_stall, m_dn);
    check("R10 up_stall", up_stall, m_up);
    check("R3 act_req", act_req, m_pend);
    if (m_pend) check("R3 act_code", act_code, m_code);
    check("R12 stn_mask_clr", stn_mask_clr, m_clr);
  endtask

  // advance the model by one clock edge using the inputs just driven
  task automatic model_step();
    logic accept, gdone;
    logic [4:0] opc;
    logic [10:0] arg;
    logic [EVT_W-1:0] ackm;
    accept = wr_en && !m_busy;
    opc = wr_data[15:11];
    arg = wr_data[10:0];
    gdone = m_pend && act_done && (m_code == 2'd0);
    ackm = (accept && opc == 5'd9) ? arg[EVT_W-1:0] : '0;
    m_evt = exp_evt(m_evt, evt_in, m_ind, ackm);
    m_clr = gdone;
    if (m_pend) begin
      if (act_done) begin m_pend = 0; m_busy = 0; end
    end else m_busy = 0;
    if (gdone) begin
      m_win = '0; m_evt = '0; m_int = '0; m_ind = '0;
      m_tx = 0; m_rx = 0; m_dn = 0; m_up = 0;
    end
    if (accept) begin
      case (opc)
        5'd0: begin m_busy = 1; m_pend = 1; m_code = 2'd0; end
        5'd2: begin m_busy = 1; m_pend = 1; m_code = 2'd1; end
        5'd3: begin m_busy = 1; m_pend = 1; m_code = 2'd2; end
        5'd1: begin m_busy = 1; m_win = arg[WIN_W-1:0]; end
        5'd4: begin m_busy = 1; m_tx = 1; end
        5'd5: begin m_busy = 1; m_tx = 0; end
        5'd6: begin m_busy = 1; m_rx = 1; end
        5'd7: begin m_busy = 1; m_rx = 0; end
        5'd8: begin
          m_busy = 1;
          if (arg[1:0] == 2'd0) m_dn = 1;
          if (arg[1:0] == 2'd1) m_dn = 0;
          if (arg[1:0] == 2'd2) m_up = 1;
          if (arg[1:0] == 2'd3) m_up = 0;
        end
        5'd9:  m_busy = 1;
        5'd10: begin m_busy = 1; m_int = arg[EVT_W-1:0]; end
        5'd11: begin m_busy = 1; m_ind = arg[EVT_W-1:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic we, input logic [4:0] opc, input logic [10:0] arg,
                      input logic [EVT_W-1:0] ev, input logic dn);
    @(negedge clk);
    compare_all();
    wr_en = we; wr_data = {opc, arg}; evt_in = ev; act_done = dn;
    model_step();
  endtask

  task automatic idle();
    step(1'b0, 5'd31, 11'd0, '0, 1'b0);
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  initial begin
    void'($urandom(32'd20251));
    model_reset();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R12 reset state
    @(negedge clk);
    check("R12 reset rd_data", rd_data, 0);
    check("R12 reset irq", irq, 0);
    idle();

    // R6 R7: enable indications and interrupts, latch an event
    step(1, 5'd11, 11'h661, '0, 0); idle();
    step(1, 5'd10, 11'h001, '0, 0); idle();
    step(0, 5'd31, 0, 11'h041, 0);
    after_edge();
    check("R7 events latched by indication", rd_data[10:0], 11'h041);
    check("R6 R9 irq from interrupt mask", irq, 1);
    // R8: acknowledge bit 0 while bit 0 fires again, clear bit 6
    step(1, 5'd9, 11'h041, 11'h001, 0);
    after_edge();
    check("R8 same-edge event survives ack", rd_data[10:0], 11'h001);
    idle();
    // R7: masked-off event is not latched
    step(0, 5'd31, 0, 11'h002, 0);
    after_edge();
    check("R7 masked event ignored", rd_data[1], 0);
    // R1: argument bits above window width ignored
    step(1, 5'd1, 11'h7FD, '0, 0);
    after_edge();
    check("R1 R5 window from argument bits", window, 5);
    check("R2 busy one cycle", rd_data[12], 1);
    idle();
    after_edge();
    check("R2 busy released", rd_data[12], 0);
    // R13: unknown opcode
    step(1, 5'd20, 11'h7FF, '0, 0);
    after_edge();
    check("R13 unknown opcode no busy", rd_data[12], 0);
    check("R13 unknown opcode no window change", window, 5);
    // R3 R4: transmit reset, write during busy discarded
    step(1, 5'd2, 0, '0, 0);
    step(1, 5'd1, 11'h002, '0, 0);
    after_edge();
    check("R4 write during busy discarded", window, 5);
    check("R3 act_code transmit", act_code, 1);
    step(0, 5'd31, 0, '0, 1);
    after_edge();
    check("R3 request dropped after done", act_req, 0);
    // R10 R11
    step(1, 5'd8, 11'h002, '0, 0); idle();
    step(1, 5'd6, 0, '0, 0); idle();
    after_edge();
    check("R10 upload stall set", up_stall, 1);
    check("R11 receive enabled", rx_en, 1);
    // R12: full reset
    step(1, 5'd0, 0, '0, 0); idle(); idle();
    step(0, 5'd31, 0, '0, 1);
    after_edge();
    check("R12 state cleared", rd_data, 0);
    check("R12 station clear pulse", stn_mask_clr, 1);
    idle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic we, dn;
      logic [4:0] opc;
      logic [10:0] arg;
      logic [EVT_W-1:0] ev;
      we  = ($urandom % 2) == 0;
      opc = 5'($urandom % 16);
      if (opc == 5'd0 && ($urandom % 8) != 0) opc = 5'd9;
      arg = 11'($urandom);
      if (opc == 5'd11 || opc == 5'd10) arg = arg | 11'($urandom);
      ev  = EVT_W'($urandom & $urandom);
      dn  = m_pend ? (($urandom % 4) == 0) : (($urandom % 8) == 0);
      step(we, opc, arg, ev, dn);
    end
    step(0, 5'd31, 0, '0, 1);
    idle();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule